// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Register Address Decoder

This block sits between a host processor's multiplexed 8-bit address/data bus and the register file of a two-channel serial controller. On each rising edge of the address strobe it captures the bus value. It then splits that value into a channel select and a 4-bit register index. Afterwards, a data-strobe cycle either produces a one-cycle write enable for the addressed write register or drives the contents of the addressed read register back onto the bus.

Two decode layouts are supported. In shift-left mode the channel bit is taken from bus bit 5, which suits programming one channel's registers in sequence. In shift-right mode it is taken from bus bit 0, so stepping the address by one alternates between the two channels at the same register index. The layout is switched by a command written to register 0 of channel B. That register sits at bus address 0 in both layouts, so the command works without knowing the current mode. Write registers 2 and 9 exist once and are shared by both channels. Read decoding is partial, so unimplemented read indices alias onto implemented ones.

Top module: `muxbus_reg_decoder`

## Requirements
- R1: The bus value is captured only in the clock cycle in which the address strobe `as_i` is first seen high. At all other times `chan_a_o` and `reg_idx_o` hold their values, whatever `ad_i` does.
- R2: After the asynchronous reset, the block is in shift-left mode (`shift_right_o`=0), all write enables are low, `ad_oe_o` is low, `chan_a_o`=0 and `reg_idx_o`=0.
- R3: In shift-left mode, the register index is `ad_i[4:1]` and the channel select is `ad_i[5]`. Bits 7:6 and bit 0 are ignored.
- R4: In shift-right mode, the register index is `ad_i[4:1]` and the channel select is `ad_i[0]`. Bits 7:5 are ignored.
- R5: A channel select of 1 addresses channel A and 0 addresses channel B, so address 0 is channel B register 0 in either mode.
- R6: A write to channel B register 0 with data bits 1:0 = 2'b10 selects shift-right mode, and with 2'b01 selects shift-left mode. Codes 2'b00 and 2'b11, and any write to channel A register 0, leave the mode unchanged.
- R7: A rising edge of `ds_ni` with `rnw_i` low produces, one cycle later, a single-cycle pulse on exactly one write-enable bit, at the position of the register index. At the same time, `wr_data_o` carries the bus value seen at that edge.
- R8: Writes to index 2 or 9 raise the matching bit of `wr_en_sh_o` whichever channel is addressed. The per-channel enables never assert for those indices.
- R9: While `ds_ni` is low and `rnw_i` is high, `ad_oe_o` is high and `ad_o` carries the addressed channel's read register. Otherwise `ad_oe_o` is low.
- R10: Read indices 0, 1, 2, 3, 8, 10, 12, 13 and 15 are implemented. Any other index i reads register i XOR 4 (4-7 map to 0-3, 9 to 13, 11 to 15, 14 to 10), and `rd_idx_o` shows the register actually read.
- R11: In shift-right mode, writing the same data to address 2k and then to address 2k+1 writes register k of channel B and then register k of channel A with identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ad_i | input | 8 | Multiplexed address/data bus, inbound |
| as_i | input | 1 | Address strobe, active high |
| ds_ni | input | 1 | Data strobe, active low |
| rnw_i | input | 1 | 1 = read, 0 = write |
| rd_regs_a_i | input | 128 | Channel A read registers, 8 bits per index |
| rd_regs_b_i | input | 128 | Channel B read registers, 8 bits per index |
| ad_o | output | 8 | Read data driven toward the bus |
| ad_oe_o | output | 1 | Bus output enable |
| chan_a_o | output | 1 | Latched channel select (1 = A) |
| reg_idx_o | output | 4 | Latched register index |
| shift_right_o | output | 1 | Current decode mode (1 = shift-right) |
| wr_en_a_o | output | 16 | Channel A write enables, one per index |
| wr_en_b_o | output | 16 | Channel B write enables, one per index |
| wr_en_sh_o | output | 16 | Shared write-register enables (bits 2, 9) |
| wr_data_o | output | 8 | Data for the pulsed write enable |
| rd_idx_o | output | 4 | Read register actually selected after aliasing |

## Verification
The bench sets bus bits outside the decoded field, so a design that picked the wrong bit would route the write to the wrong channel. It also moves the bus with no address strobe, so a latch that is transparent would change the address it holds. Mode commands are sent from channel A and with invalid codes. A decoder that matched on the register index alone, or on any nonzero code, would flip the mode at those points. Shared registers are written from both channels, and a design that split them would pulse a per-channel enable. Every read index in both channels is swept, so a missing or wrong alias shows up as a wrong `ad_o` value or a wrong `rd_idx_o`.

// File: rtl/muxbus_reg_pkg.sv
package muxbus_reg_pkg;
  localparam int unsigned NREG = 16;
  localparam int unsigned IW   = 4;
  // Write registers present once, shared by both channels
  localparam logic [NREG-1:0] SHARED_MASK = 16'h0204;
  // Read indices with real storage
  localparam logic [NREG-1:0] IMPL_MASK   = 16'hB50F;
  localparam logic [1:0] CMD_SHL = 2'b01;
  localparam logic [1:0] CMD_SHR = 2'b10;

  // Unimplemented read indices fold onto index XOR 4
  function automatic logic [IW-1:0] canon_idx(input logic [IW-1:0] i);
    return IMPL_MASK[i] ? i : (i ^ IW'(4));
  endfunction
endpackage

// File: rtl/muxbus_addr_latch.sv
module muxbus_addr_latch #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ad_i,
  input  logic          as_i,
  input  logic          shift_right_i,
  output logic          chan_a_o,
  output logic [IW-1:0] idx_o
);
  localparam int unsigned SHL_CH_BIT = IW + 1;

  logic as_q;
  logic as_rise;
  assign as_rise = as_i & ~as_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q     <= 1'b0;
      chan_a_o <= 1'b0;
      idx_o    <= '0;
    end else begin
      as_q <= as_i;
      if (as_rise) begin
        chan_a_o <= shift_right_i ? ad_i[0] : ad_i[SHL_CH_BIT];
        idx_o    <= ad_i[IW:1];
      end
    end
  end

  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_rise |=> $stable({chan_a_o, idx_o}));
  // R3
  shl_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_rise && !shift_right_i) |=>
      (chan_a_o == $past(ad_i[SHL_CH_BIT]) && idx_o == $past(ad_i[IW:1])));
  // R4
  shr_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_rise && shift_right_i) |=>
      (chan_a_o == $past(ad_i[0]) && idx_o == $past(ad_i[IW:1])));
endmodule

// File: rtl/muxbus_mode_reg.sv
module muxbus_mode_reg
  import muxbus_reg_pkg::*;
#(
  parameter int unsigned IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic          chan_a_i,
  input  logic [IW-1:0] idx_i,
  input  logic [1:0]    cmd_i,
  output logic          shift_right_o
);
  logic cmd_hit;
  assign cmd_hit = wr_stb_i & ~chan_a_i & (idx_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_right_o <= 1'b0;
    end else if (cmd_hit) begin
      case (cmd_i)
        CMD_SHL: shift_right_o <= 1'b0;
        CMD_SHR: shift_right_o <= 1'b1;
        default: ;
      endcase
    end
  end

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_hit |=> $stable(shift_right_o));
endmodule

// File: rtl/muxbus_wr_decode.sv
module muxbus_wr_decode
  import muxbus_reg_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NR   = 16,
  parameter int unsigned IW   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic          chan_a_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  output logic [NR-1:0] wr_en_a_o,
  output logic [NR-1:0] wr_en_b_o,
  output logic [NR-1:0] wr_en_sh_o,
  output logic [DW-1:0] wr_data_o
);
  logic [NR-1:0] sel;
  logic [NR-1:0] shared;

  for (genvar g = 0; g < NR; g++) begin : g_sel
    assign sel[g]    = wr_stb_i && (idx_i == IW'(g));
    assign shared[g] = SHARED_MASK[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_a_o  <= '0;
      wr_en_b_o  <= '0;
      wr_en_sh_o <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_a_o  <= sel & ~shared & {NR{chan_a_i}};
      wr_en_b_o  <= sel & ~shared & {NR{~chan_a_i}};
      wr_en_sh_o <= sel & shared;
      if (wr_stb_i) wr_data_o <= data_i;
    end
  end

  // R7
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_a_o, wr_en_b_o, wr_en_sh_o}));
  // R7
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{wr_en_a_o, wr_en_b_o, wr_en_sh_o}) |=> !(|{wr_en_a_o, wr_en_b_o, wr_en_sh_o}));
  // R8
  shared_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && SHARED_MASK[idx_i]) |=> (|wr_en_sh_o) && !(|{wr_en_a_o, wr_en_b_o}));
endmodule

// File: rtl/muxbus_rd_mux.sv
module muxbus_rd_mux
  import muxbus_reg_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NR = 16,
  parameter int unsigned IW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NR*DW-1:0] rd_regs_a_i,
  input  logic [NR*DW-1:0] rd_regs_b_i,
  input  logic             chan_a_i,
  input  logic [IW-1:0]    idx_i,
  output logic [IW-1:0]    rd_idx_o,
  output logic [DW-1:0]    rd_data_o
);
  always_comb begin
    rd_idx_o  = canon_idx(idx_i);
    rd_data_o = chan_a_i ? rd_regs_a_i[rd_idx_o*DW +: DW]
                         : rd_regs_b_i[rd_idx_o*DW +: DW];
  end

  // R10
  alias_impl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    IMPL_MASK[rd_idx_o]);
  // R10
  alias_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    IMPL_MASK[idx_i] |-> (rd_idx_o == idx_i));
endmodule

// File: rtl/muxbus_reg_decoder.sv
module muxbus_reg_decoder #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DW-1:0]      ad_i,
  input  logic               as_i,
  input  logic               ds_ni,
  input  logic               rnw_i,
  input  logic [NREG*DW-1:0] rd_regs_a_i,
  input  logic [NREG*DW-1:0] rd_regs_b_i,
  output logic [DW-1:0]      ad_o,
  output logic               ad_oe_o,
  output logic               chan_a_o,
  output logic [IW-1:0]      reg_idx_o,
  output logic               shift_right_o,
  output logic [NREG-1:0]    wr_en_a_o,
  output logic [NREG-1:0]    wr_en_b_o,
  output logic [NREG-1:0]    wr_en_sh_o,
  output logic [DW-1:0]      wr_data_o,
  output logic [IW-1:0]      rd_idx_o
);
  logic          ds_q;
  logic          wr_stb;
  logic [DW-1:0] rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ds_q <= 1'b1;
    else         ds_q <= ds_ni;
  end

  // write commits on the trailing (rising) edge of the data strobe
  assign wr_stb  = ds_ni & ~ds_q & ~rnw_i;
  assign ad_oe_o = ~ds_ni & rnw_i;
  assign ad_o    = ad_oe_o ? rd_data : '0;

  muxbus_addr_latch #(.DW(DW), .IW(IW)) u_latch (
    .clk_i, .rst_ni, .ad_i, .as_i,
    .shift_right_i (shift_right_o),
    .chan_a_o      (chan_a_o),
    .idx_o         (reg_idx_o)
  );

  muxbus_mode_reg #(.IW(IW)) u_mode (
    .clk_i, .rst_ni,
    .wr_stb_i      (wr_stb),
    .chan_a_i      (chan_a_o),
    .idx_i         (reg_idx_o),
    .cmd_i         (ad_i[1:0]),
    .shift_right_o (shift_right_o)
  );

  muxbus_wr_decode #(.DW(DW), .NR(NREG), .IW(IW)) u_wr (
    .clk_i, .rst_ni,
    .wr_stb_i   (wr_stb),
    .chan_a_i   (chan_a_o),
    .idx_i      (reg_idx_o),
    .data_i     (ad_i),
    .wr_en_a_o  (wr_en_a_o),
    .wr_en_b_o  (wr_en_b_o),
    .wr_en_sh_o (wr_en_sh_o),
    .wr_data_o  (wr_data_o)
  );

  muxbus_rd_mux #(.DW(DW), .NR(NREG), .IW(IW)) u_rd (
    .clk_i, .rst_ni, .rd_regs_a_i, .rd_regs_b_i,
    .chan_a_i  (chan_a_o),
    .idx_i     (reg_idx_o),
    .rd_idx_o  (rd_idx_o),
    .rd_data_o (rd_data)
  );

  // R9
  no_drive_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rnw_i |-> !ad_oe_o);
endmodule

// File: tb/tb_muxbus_reg_decoder.sv
module tb_muxbus_reg_decoder;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       ch_a;
    logic [3:0] idx;
    logic [7:0] data;
  } wr_item_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [7:0]   ad_i = '0;
  logic         as_i = 1'b0;
  logic         ds_ni = 1'b1;
  logic         rnw_i = 1'b1;
  logic [127:0] rd_regs_a_i, rd_regs_b_i;
  logic [7:0]   ad_o, wr_data_o;
  logic         ad_oe_o, chan_a_o, shift_right_o;
  logic [3:0]   reg_idx_o, rd_idx_o;
  logic [15:0]  wr_en_a_o, wr_en_b_o, wr_en_sh_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic tb_mode = 1'b0;
  wr_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  muxbus_reg_decoder dut (.*);

  function automatic logic [7:0] rd_val(input logic ch_a, input logic [3:0] i);
    return {ch_a, i, 3'b101};
  endfunction

  function automatic logic [3:0] exp_canon(input logic [3:0] i);
    case (i)
      4'd4, 4'd5, 4'd6, 4'd7: return i - 4'd4;
      4'd9:  return 4'd13;
      4'd11: return 4'd15;
      4'd14: return 4'd10;
      default: return i;
    endcase
  endfunction

  function automatic logic [7:0] mk_addr(input logic ch_a, input logic [3:0] i,
                                         input logic [1:0] junk);
    if (tb_mode) return {junk, 1'b1, i, ch_a};
    else         return {junk, ch_a, i, 1'b0};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put_addr(input logic [7:0] a);
    @(negedge clk_i); ad_i = a; as_i = 1'b1;
    @(negedge clk_i); as_i = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic ch_a, input logic [3:0] i,
                           input logic [7:0] d);
    put_addr(a);
    exp_q.push_back('{ch_a: ch_a, idx: i, data: d});
    @(negedge clk_i); ad_i = d; rnw_i = 1'b0; ds_ni = 1'b0;
    @(negedge clk_i); ds_ni = 1'b1;
    @(negedge clk_i); rnw_i = 1'b1;
    if (!ch_a && i == 4'd0) begin
      if (d[1:0] == 2'b10) tb_mode = 1'b1;
      else if (d[1:0] == 2'b01) tb_mode = 1'b0;
    end
  endtask

  task automatic reg_write(input logic ch_a, input logic [3:0] i, input logic [7:0] d);
    bus_write(mk_addr(ch_a, i, 2'b11), ch_a, i, d);
  endtask

  task automatic reg_read(input logic ch_a, input logic [3:0] i);
    logic [3:0] c;
    c = exp_canon(i);
    put_addr(mk_addr(ch_a, i, 2'b10));
    @(negedge clk_i); rnw_i = 1'b1; ds_ni = 1'b0;
    #1;
    check(ad_oe_o == 1'b1, "R9 oe", ad_oe_o, 1);
    check(rd_idx_o == c, "R10 rd_idx", rd_idx_o, c);
    check(ad_o == rd_val(ch_a, c), "R9/R10 data", ad_o, rd_val(ch_a, c));
    @(negedge clk_i); ds_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && (|{wr_en_a_o, wr_en_b_o, wr_en_sh_o})) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected write", {wr_en_a_o, wr_en_b_o}, 0);
      end else begin
        wr_item_t e;
        logic sh;
        logic [15:0] ea, eb, es;
        e  = exp_q.pop_front();
        sh = (e.idx == 4'd2) || (e.idx == 4'd9);
        es = sh ? (16'd1 << e.idx) : 16'd0;
        ea = (!sh && e.ch_a)  ? (16'd1 << e.idx) : 16'd0;
        eb = (!sh && !e.ch_a) ? (16'd1 << e.idx) : 16'd0;
        check(wr_en_a_o == ea, "R7/R5 wr_en_a", wr_en_a_o, ea);
        check(wr_en_b_o == eb, "R7/R5 wr_en_b", wr_en_b_o, eb);
        check(wr_en_sh_o == es, "R8 wr_en_sh", wr_en_sh_o, es);
        check(wr_data_o == e.data, "R7 wr_data", wr_data_o, e.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rd_regs_a_i[i*8 +: 8] = rd_val(1'b1, 4'(i));
      rd_regs_b_i[i*8 +: 8] = rd_val(1'b0, 4'(i));
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 reset state
    check(shift_right_o == 1'b0, "R2 mode", shift_right_o, 0);
    check({wr_en_a_o, wr_en_b_o, wr_en_sh_o} == '0, "R2 enables", 1, 0);
    check(ad_oe_o == 1'b0, "R2 oe", ad_oe_o, 0);
    check(chan_a_o == 1'b0 && reg_idx_o == 4'd0, "R2 addr", {chan_a_o, reg_idx_o}, 0);

    // R3 R5 shift-left decode, junk in bits 7:6 and 0
    put_addr(8'b1110_1011);
    check(chan_a_o == 1'b1, "R3 chan", chan_a_o, 1);
    check(reg_idx_o == 4'd5, "R3 idx", reg_idx_o, 5);
    // R1 bus moves with no strobe
    @(negedge clk_i); ad_i = 8'h00;
    @(negedge clk_i); ad_i = 8'h5E;
    @(negedge clk_i);
    check(chan_a_o == 1'b1 && reg_idx_o == 4'd5, "R1 hold", {chan_a_o, reg_idx_o}, 8'h15);

    // R7 plain writes in shift-left
    reg_write(1'b1, 4'd3, 8'hA5);
    reg_write(1'b0, 4'd12, 8'h3C);
    // R8 shared registers from both channels
    reg_write(1'b1, 4'd9, 8'h71);
    reg_write(1'b0, 4'd2, 8'h0F);
    reg_write(1'b1, 4'd2, 8'hE2);

    // R6 mode commands that must not switch
    reg_write(1'b1, 4'd0, 8'h02);
    check(shift_right_o == 1'b0, "R6 chan A cmd ignored", shift_right_o, 0);
    reg_write(1'b0, 4'd0, 8'h03);
    check(shift_right_o == 1'b0, "R6 code 11 ignored", shift_right_o, 0);
    reg_write(1'b0, 4'd0, 8'h00);
    check(shift_right_o == 1'b0, "R6 code 00 ignored", shift_right_o, 0);
    reg_write(1'b0, 4'd0, 8'h02);
    check(shift_right_o == 1'b1, "R6 to shift-right", shift_right_o, 1);

    // R4 shift-right decode, bit 5 set must not matter
    put_addr(8'b1110_0110);
    check(chan_a_o == 1'b0, "R4 chan", chan_a_o, 0);
    check(reg_idx_o == 4'd3, "R4 idx", reg_idx_o, 3);

    // R11 address increment alternates channels with identical data
    for (int k = 1; k < 16; k++) begin
      bus_write(8'(2*k),     1'b0, 4'(k), 8'(8'h40 + k));
      bus_write(8'(2*k + 1), 1'b1, 4'(k), 8'(8'h40 + k));
    end

    // R9 R10 read sweep, both channels, every index
    for (int i = 0; i < 16; i++) begin
      reg_read(1'b0, 4'(i));
      reg_read(1'b1, 4'(i));
    end
    @(negedge clk_i);
    check(ad_oe_o == 1'b0, "R9 idle oe", ad_oe_o, 0);

    // R6 back to shift-left from address 0
    bus_write(8'h00, 1'b0, 4'd0, 8'h01);
    check(shift_right_o == 1'b0, "R6 to shift-left", shift_right_o, 0);
    reg_read(1'b1, 4'd13);

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R7 missing writes", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule